// File: doc/BRIEF.md
# Step Attenuator Control Register

This block is the digital front end of a six-bit step attenuator. It turns either a four-wire serial word or six parallel control lines into a held six-bit attenuation code for the switch array. The bits are weighted 0.5, 1, 2, 4, 8 and 16 dB. A mode input picks the interface. One latch-enable input carries three meanings: a transfer strobe in serial mode, a capture strobe in latched parallel mode, and a transparent level in direct parallel mode.

All pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the serial clock and latch-enable edges are found inside the block. A serial output repeats the input stream eight serial clocks late, so several attenuators can share one serial bus in a chain. There is no streaming data path here, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level, and a source must hold each serial clock phase and each strobe level for at least three system clocks.

Top module: `atten_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `atten_code` is 6'b111111 (31.5 dB, maximum attenuation) and `ser_out` is 0.
- R2: With `ser_mode`=1 and `latch_en`=0, each rising edge of `ser_clk` samples `ser_in`, most significant bit first. A rising edge on `latch_en` then loads the last six bits into `atten_code`: the sixth bit from the end goes to bit 5 and the last bit to bit 0.
- R3: An eight-bit word loads the same code as its last six bits. The two leading bits have no effect on `atten_code`.
- R4: In serial mode, `ser_clk` edges that arrive while `latch_en` is high do not change the shift register. A later strobe loads the earlier word, and `ser_out` stays unchanged.
- R5: After the n-th accepted `ser_clk` rising edge, `ser_out` equals the bit sampled at edge n-7. Before eight edges have been accepted it shows 0.
- R6: In serial mode, `atten_code` changes only on a rising edge of `latch_en`. Shifting, and holding `latch_en` high, leave it unchanged.
- R7: With `ser_mode`=0, changes on `par_code` while `latch_en` is low do not affect `atten_code`. Raising `latch_en` passes `par_code` through, and lowering it holds the value last seen.
- R8: With `ser_mode`=0 and `latch_en` held high, `atten_code` follows `par_code` continuously.
- R9: In serial mode, `par_code` has no effect on `atten_code`, even while `latch_en` is high.
- R10: In parallel mode, `ser_clk` edges do not shift. `ser_out` and the serial history are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ser_mode | input | 1 | 1 selects serial control, 0 selects parallel control |
| latch_en | input | 1 | Strobe in serial and latched parallel modes; held high for direct parallel mode |
| ser_clk | input | 1 | Serial clock, sampled on rising edges |
| ser_in | input | 1 | Serial data in, most significant bit first |
| par_code | input | 6 | Parallel code; bit 0 is 0.5 dB, bit 5 is 16 dB |
| ser_out | output | 1 | Serial data out, always driven, eight serial clocks behind `ser_in` |
| atten_code | output | 6 | Held attenuation code; all zeros is the reference state |

## Verification
The bench feeds eight-bit words with random leading bits. A design that loaded the wrong window would report those bits in the code. It toggles the serial clock with the strobe held high, then strobes again. A design that did not mask the clock would load the junk shifted in while the strobe was high. It checks the serial output after every bit against a model of the input history, and also after serial clocks sent in parallel mode, which catches an off-by-one delay or shifting in the wrong mode. In both modes it changes the parallel lines with the strobe high and low, which separates transparent, latched and ignored behaviour.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W  = 6;
  localparam int CHAIN_W = 8;
  localparam int SYNC_N  = 2;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_MAX = '1;
endpackage

// File: rtl/sync_bus.sv
module sync_bus #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rise_det.sv
module rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/serial_chain.sv
module serial_chain #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stages <= '0;
    else if (shift) stages <= {stages[DEPTH-2:0], din};
  end
endmodule

// File: rtl/code_hold.sv
module code_hold
  import atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ser_sel,
  input  logic  strobe_rise,
  input  logic  strobe_lvl,
  input  code_t ser_word,
  input  code_t par_word,
  output code_t code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= CODE_MAX;
    end else if (ser_sel) begin
      if (strobe_rise) code <= ser_word;
    end else if (strobe_lvl) begin
      code <= par_word;
    end
  end
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              latch_en,
  input  logic              ser_clk,
  input  logic              ser_in,
  input  logic [CODE_W-1:0] par_code,
  output logic              ser_out,
  output logic [CODE_W-1:0] atten_code
);
  localparam int BUS_W = CODE_W + 4;

  logic [BUS_W-1:0]   raw_bus, sync_q;
  logic               mode_s, le_s, sclk_s, sdat_s;
  code_t              par_s;
  logic [1:0]         rises;
  logic               sclk_rise, le_rise, shift_en;
  logic [CHAIN_W-1:0] sh_q;
  code_t              code_q;

  assign raw_bus = {ser_mode, latch_en, ser_clk, ser_in, par_code};

  sync_bus #(.W(BUS_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_q)
  );

  assign {mode_s, le_s, sclk_s, sdat_s, par_s} = sync_q;

  rise_det #(.W(2)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl({le_s, sclk_s}), .rise(rises)
  );

  assign le_rise   = rises[1];
  assign sclk_rise = rises[0];
  assign shift_en  = mode_s & ~le_s & sclk_rise;

  serial_chain #(.DEPTH(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift(shift_en), .din(sdat_s), .stages(sh_q)
  );

  code_hold u_code (
    .clk(clk), .rst_n(rst_n), .ser_sel(mode_s), .strobe_rise(le_rise),
    .strobe_lvl(le_s), .ser_word(sh_q[CODE_W-1:0]), .par_word(par_s),
    .code(code_q)
  );

  assign ser_out    = sh_q[CHAIN_W-1];
  assign atten_code = code_q;
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk
  import atten_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mode_s,
  input logic               le_s,
  input logic               le_rise,
  input logic               sclk_rise,
  input code_t              par_s,
  input logic [CHAIN_W-1:0] sh_q,
  input logic               ser_out,
  input code_t              atten_code
);
  // R4
  le_high_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> $stable(sh_q));

  // R10
  par_mode_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> $stable(sh_q));

  // R5
  serout_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !le_s && sclk_rise) |=> ser_out == $past(sh_q[CHAIN_W-2]));

  // R6
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !le_rise) |=> $stable(atten_code));

  // R2
  ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_rise) |=> atten_code == $past(sh_q[CODE_W-1:0]));

  // R7
  par_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !le_s) |=> $stable(atten_code));

  // R8
  par_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && le_s) |=> atten_code == $past(par_s));
endmodule

bind atten_ctrl atten_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .le_s(le_s), .le_rise(le_rise),
  .sclk_rise(sclk_rise), .par_s(par_s), .sh_q(sh_q), .ser_out(ser_out),
  .atten_code(atten_code)
);

// File: tb/tb_atten_ctrl.sv
`timescale 1ns/1ps
module tb_atten_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ser_mode = 1, latch_en = 0, ser_clk = 0, ser_in = 0;
  logic [5:0] par_code = 0;
  logic       ser_out;
  logic [5:0] atten_code;

  int checks = 0, errors = 0;
  int hist [0:8191];
  int nb = 0;
  logic [5:0] exp_code;

  always #2 clk = ~clk;

  atten_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .latch_en(latch_en),
    .ser_clk(ser_clk), .ser_in(ser_in), .par_code(par_code),
    .ser_out(ser_out), .atten_code(atten_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_serout();
    return (nb >= 8) ? hist[nb-8] : 0;
  endfunction

  function automatic logic [5:0] last_six();
    logic [5:0] v = '0;
    for (int k = 0; k < 6; k++) v[k] = hist[nb-1-k][0];
    return v;
  endfunction

  // one serial bit; recorded when it will be accepted
  task automatic ser_bit(input logic b, input logic accepted);
    @(negedge clk); ser_in = b;
    wait_n(3); ser_clk = 1;
    wait_n(4); ser_clk = 0;
    wait_n(4);
    if (accepted) begin hist[nb] = int'(b); nb++; end
  endtask

  task automatic send_word(input logic [7:0] w, input int nbits);
    for (int i = nbits-1; i >= 0; i--) begin
      ser_bit(w[i], 1'b1);
      chk("R5 serout", int'(ser_out), exp_serout());
    end
  endtask

  task automatic le_pulse();
    @(negedge clk); latch_en = 1; wait_n(6);
    latch_en = 0; wait_n(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    wait_n(2);
    chk("R1 code in reset", int'(atten_code), 63);
    rst_n = 1;
    wait_n(6);
    chk("R1 code after reset", int'(atten_code), 63);
    chk("R1 serout after reset", int'(ser_out), 0);

    // R2 six-bit word, R6 hold while shifting
    send_word(8'h2A, 6);
    chk("R6 code before strobe", int'(atten_code), 63);
    le_pulse();
    chk("R2 six-bit load", int'(atten_code), 'h2A);

    // R3 eight-bit word, leading bits ignored
    send_word(8'hC5, 8);
    le_pulse();
    chk("R3 eight-bit load", int'(atten_code), 'h05);
    send_word(8'h80, 8);
    le_pulse();
    chk("R3 leading ones ignored", int'(atten_code), 'h00);
    exp_code = 6'h00;

    // R4 clock masked while LE high; R6 code held at LE high level
    @(negedge clk); latch_en = 1; wait_n(6);
    for (int i = 0; i < 6; i++) ser_bit(1'b1, 1'b0);
    chk("R6 code steady with LE high", int'(atten_code), int'(exp_code));
    chk("R4 serout unchanged", int'(ser_out), exp_serout());
    latch_en = 0; wait_n(6);
    le_pulse();
    chk("R4 masked clocks not loaded", int'(atten_code), int'(last_six()));

    // R9 parallel lines ignored in serial mode
    @(negedge clk); latch_en = 1; par_code = 6'h15; wait_n(8);
    chk("R9 par ignored in serial", int'(atten_code), int'(exp_code));
    latch_en = 0; wait_n(6);

    // random serial words
    for (int t = 0; t < 20; t++) begin
      logic [7:0] w = 8'($urandom);
      int n = ($urandom % 2) ? 8 : 6;
      send_word(w, n);
      le_pulse();
      chk("R2 random serial load", int'(atten_code), int'(w[5:0]));
    end
    exp_code = atten_code;

    // parallel latched mode
    @(negedge clk); ser_mode = 0; par_code = 6'h2D; wait_n(8);
    chk("R7 par change with LE low", int'(atten_code), int'(exp_code));
    latch_en = 1; wait_n(6);
    chk("R7 strobe passes par", int'(atten_code), 'h2D);
    latch_en = 0; wait_n(6);
    par_code = 6'h12; wait_n(8);
    chk("R7 held after LE low", int'(atten_code), 'h2D);
    for (int t = 0; t < 10; t++) begin
      logic [5:0] a = 6'($urandom);
      logic [5:0] b = 6'($urandom);
      @(negedge clk); par_code = a; wait_n(4);
      latch_en = 1; wait_n(6); latch_en = 0; wait_n(6);
      par_code = b; wait_n(6);
      chk("R7 random latched", int'(atten_code), int'(a));
    end

    // R8 direct mode
    @(negedge clk); latch_en = 1;
    for (int t = 0; t < 12; t++) begin
      logic [5:0] a = (t == 0) ? 6'h00 : (t == 1) ? 6'h3F : 6'($urandom);
      @(negedge clk); par_code = a; wait_n(6);
      chk("R8 direct follow", int'(atten_code), int'(a));
    end
    latch_en = 0; wait_n(6);

    // R10 serial clocks ignored in parallel mode
    for (int i = 0; i < 8; i++) ser_bit(~ser_out, 1'b0);
    chk("R10 serout unchanged in parallel", int'(ser_out), exp_serout());
    @(negedge clk); ser_mode = 1; wait_n(6);
    send_word(8'h3B, 6);
    le_pulse();
    chk("R10 history intact", int'(atten_code), 'h3B);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule